// File: doc/BRIEF.md
# Network Identity Bring-Up Sequencer

This block takes an SPI-attached network controller from reset to a known network identity. On a start pulse it holds the controller's active-low reset pin low for a set number of clock cycles and then releases it. It then waits a second set number of cycles so the controller can settle. Only after that does it send register requests to a framed SPI master.

The controller needs four identity fields: the 6-byte hardware (MAC) address, the 4-byte IPv4 address, the 4-byte subnet mask and the 4-byte gateway. Each field goes out as a single multi-byte write frame, so chip select frames one field at a time. The fields are sent in that fixed order. After the fourth write, the sequencer reads every field back in the same order and compares each one with the value it wrote.

When all four read-backs match, the sequencer reports done, and socket setup may begin. At the first mismatch it stops and raises an error flag along with a 2-bit code that names the failing field. A later start pulse retries the whole sequence, beginning again with the reset.

Top module: `netid_bringup`

## Requirements
- R1: While `rst_n` is low and after its release, before any start, `nic_rst_n` is high and `req_valid`, `busy`, `done` and `error` are all low.
- R2: A `start` pulse accepted when idle, done or failed drives `nic_rst_n` low for exactly `HOLD_CYC` clock cycles.
- R3: `req_valid` stays low while `nic_rst_n` is low. The first request appears exactly `SETTLE_CYC` cycles after `nic_rst_n` returns high.
- R4: The first four requests are writes (`req_write`=1) in this order:
  - MAC at `MAC_OFS` with `req_len`=6;
  - IPv4 at `IP_OFS` with `req_len`=4;
  - mask at `MASK_OFS` with `req_len`=4;
  - gateway at `GW_OFS` with `req_len`=4.

  Data is right-aligned in `req_wdata`, with the first wire byte most significant and unused upper bytes zero.
- R5: After the fourth write, read requests (`req_write`=0) follow for the same four fields, in the same order, with the same offsets and lengths.
- R6: A request holds `req_valid` and its address, direction and data stable until `req_ready`. No new request is raised after acceptance until `rsp_valid` returns.
- R7: Each read response is compared over all 48 bits of `rsp_rdata` with the zero-extended field. On a mismatch the sequencer raises `error` and sets `err_field` (0 MAC, 1 IPv4, 2 mask, 3 gateway). It then issues no further requests.
- R8: When all four read-backs match, `done` goes high with `busy` and `req_valid` low.
- R9: `start` is ignored while `busy` is high. In the done or failed state, `start` restarts the sequence from reset.
- R10: `done` and `error` are never high together. Each one, and `err_field`, holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | Pulse to begin or retry bring-up |
| mac_addr | input | 48 | MAC address to load, first wire byte in bits 47:40 |
| ip_addr | input | 32 | IPv4 address to load |
| net_mask | input | 32 | Subnet mask to load |
| gw_addr | input | 32 | Gateway address to load |
| nic_rst_n | output | 1 | Active-low reset pin of the network controller |
| req_valid | output | 1 | Register request pending to the SPI master |
| req_ready | input | 1 | SPI master accepts the request |
| req_write | output | 1 | 1 = write frame, 0 = read frame |
| req_addr | output | 16 | Register offset in the common block |
| req_len | output | 3 | Number of data bytes in the frame |
| req_wdata | output | 48 | Write data, right-aligned |
| rsp_valid | input | 1 | SPI master finished the frame |
| rsp_rdata | input | 48 | Read data, right-aligned, upper bytes zero |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All fields written and verified |
| error | output | 1 | A read-back mismatch stopped the sequence |
| err_field | output | 2 | Code of the failing field while error is high |

## Verification
Every result has a fixed cycle offset from its stimulus. The reset pin falls on the first edge after `start` and stays low for `HOLD_CYC` samples. The first request follows after `SETTLE_CYC` high samples. Each later request appears on the cycle after the response that ends the previous one, and `done` or `error` is set on the edge that samples the last response.

The bench samples at the falling edge and counts cycles between these points, so it checks exact counts rather than waiting loosely. Its responder model logs every request and injects read-back corruption into each field in turn. One corruption case differs from the written value only in the padding bits. Another case pulses `start` in the middle of a run.

// File: rtl/netid_bringup_pkg.sv
package netid_bringup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  localparam logic [1:0] FLD_MAC  = 2'd0;
  localparam logic [1:0] FLD_IP   = 2'd1;
  localparam logic [1:0] FLD_MASK = 2'd2;
  localparam logic [1:0] FLD_GW   = 2'd3;
  localparam int         DATA_W   = 48;
endpackage

// File: rtl/netid_delay.sv
module netid_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/netid_field_sel.sv
module netid_field_sel
  import netid_bringup_pkg::*;
#(
  parameter logic [15:0] MAC_OFS  = 16'h0009,
  parameter logic [15:0] IP_OFS   = 16'h000F,
  parameter logic [15:0] MASK_OFS = 16'h0005,
  parameter logic [15:0] GW_OFS   = 16'h0001
) (
  input  logic [1:0]        idx,
  input  logic [47:0]       mac_addr,
  input  logic [31:0]       ip_addr,
  input  logic [31:0]       net_mask,
  input  logic [31:0]       gw_addr,
  output logic [15:0]       addr,
  output logic [2:0]        len,
  output logic [DATA_W-1:0] value
);
  always_comb begin
    unique case (idx)
      FLD_MAC: begin
        addr  = MAC_OFS;
        len   = 3'd6;
        value = mac_addr;
      end
      FLD_IP: begin
        addr  = IP_OFS;
        len   = 3'd4;
        value = {16'h0000, ip_addr};
      end
      FLD_MASK: begin
        addr  = MASK_OFS;
        len   = 3'd4;
        value = {16'h0000, net_mask};
      end
      default: begin
        addr  = GW_OFS;
        len   = 3'd4;
        value = {16'h0000, gw_addr};
      end
    endcase
  end
endmodule

// File: rtl/netid_bringup.sv
module netid_bringup
  import netid_bringup_pkg::*;
#(
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          HOLD_CYC   = CLK_HZ / 1_000_000 * 500,
  parameter int          SETTLE_CYC = CLK_HZ / 1_000_000 * 1000,
  parameter logic [15:0] MAC_OFS    = 16'h0009,
  parameter logic [15:0] IP_OFS     = 16'h000F,
  parameter logic [15:0] MASK_OFS   = 16'h0005,
  parameter logic [15:0] GW_OFS     = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] mac_addr,
  input  logic [31:0] ip_addr,
  input  logic [31:0] net_mask,
  input  logic [31:0] gw_addr,
  output logic        nic_rst_n,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic [15:0] req_addr,
  output logic [2:0]  req_len,
  output logic [47:0] req_wdata,
  input  logic        rsp_valid,
  input  logic [47:0] rsp_rdata,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [1:0]  err_field
);
  localparam int MAX_CYC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);

  seq_state_t  st_q, st_d;
  logic        rd_q, rd_d;
  logic [1:0]  idx_q, idx_d;
  logic [1:0]  ef_q, ef_d;
  logic        tmr_load;
  logic [CW-1:0] tmr_val;
  logic        tmr_zero;
  logic [DATA_W-1:0] fld_value;

  netid_delay #(.CW(CW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  netid_field_sel #(
    .MAC_OFS (MAC_OFS),
    .IP_OFS  (IP_OFS),
    .MASK_OFS(MASK_OFS),
    .GW_OFS  (GW_OFS)
  ) u_field (
    .idx      (idx_q),
    .mac_addr (mac_addr),
    .ip_addr  (ip_addr),
    .net_mask (net_mask),
    .gw_addr  (gw_addr),
    .addr     (req_addr),
    .len      (req_len),
    .value    (fld_value)
  );

  always_comb begin
    st_d     = st_q;
    rd_d     = rd_q;
    idx_d    = idx_q;
    ef_d     = ef_q;
    tmr_load = 1'b0;
    tmr_val  = HOLD_LD;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          st_d     = ST_HOLD;
          rd_d     = 1'b0;
          idx_d    = FLD_MAC;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          st_d     = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) st_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          if (rd_q && (rsp_rdata != fld_value)) begin
            st_d = ST_FAIL;
            ef_d = idx_q;
          end else if (idx_q == FLD_GW) begin
            if (rd_q) begin
              st_d = ST_DONE;
            end else begin
              st_d  = ST_ISSUE;
              rd_d  = 1'b1;
              idx_d = FLD_MAC;
            end
          end else begin
            st_d  = ST_ISSUE;
            idx_d = idx_q + 2'd1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rd_q  <= 1'b0;
      idx_q <= FLD_MAC;
      ef_q  <= FLD_MAC;
    end else begin
      st_q  <= st_d;
      rd_q  <= rd_d;
      idx_q <= idx_d;
      ef_q  <= ef_d;
    end
  end

  assign nic_rst_n = (st_q != ST_HOLD);
  assign req_valid = (st_q == ST_ISSUE);
  assign req_write = ~rd_q;
  assign req_wdata = fld_value;
  assign busy      = (st_q != ST_IDLE) && (st_q != ST_DONE) && (st_q != ST_FAIL);
  assign done      = (st_q == ST_DONE);
  assign error     = (st_q == ST_FAIL);
  assign err_field = ef_q;
endmodule

// File: rtl/netid_bringup_chk.sv
module netid_bringup_chk #(
  parameter int HOLD_CYC   = 4,
  parameter int SETTLE_CYC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        nic_rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic [47:0] req_wdata,
  input logic        rsp_valid,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic [1:0]  err_field
);
  int   low_cnt;
  int   high_cnt;
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt     <= 0;
      high_cnt    <= 0;
      outstanding <= 1'b0;
    end else begin
      if (!nic_rst_n) low_cnt <= low_cnt + 1;
      else            low_cnt <= 0;
      if (!nic_rst_n)                 high_cnt <= 0;
      else if (high_cnt < SETTLE_CYC) high_cnt <= high_cnt + 1;
      if (req_valid && req_ready) outstanding <= 1'b1;
      else if (rsp_valid)         outstanding <= 1'b0;
    end
  end

  assert_hold_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nic_rst_n) |-> low_cnt == HOLD_CYC);

  assert_no_req_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !nic_rst_n |-> !req_valid);

  assert_settled_before_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> high_cnt >= SETTLE_CYC);

  assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
                               && $stable(req_wdata));

  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !req_valid);

  assert_quiet_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !req_valid && !busy);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_error_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && $stable(err_field));

  assert_done_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
endmodule

bind netid_bringup netid_bringup_chk #(
  .HOLD_CYC  (HOLD_CYC),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .nic_rst_n (nic_rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .err_field (err_field)
);

// File: tb/netid_bringup_bench.sv
module netid_bringup_bench;
  localparam int          HOLD   = 7;
  localparam int          SETTLE = 11;
  localparam logic [15:0] O_MAC  = 16'h0009;
  localparam logic [15:0] O_IP   = 16'h000F;
  localparam logic [15:0] O_MASK = 16'h0005;
  localparam logic [15:0] O_GW   = 16'h0001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [47:0] mac_addr;
  logic [31:0] ip_addr, net_mask, gw_addr;
  logic        nic_rst_n, req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [2:0]  req_len;
  logic [47:0] req_wdata;
  logic        rsp_valid;
  logic [47:0] rsp_rdata;
  logic        busy, done, error;
  logic [1:0]  err_field;

  always #5 clk = ~clk;

  netid_bringup #(
    .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE),
    .MAC_OFS(O_MAC), .IP_OFS(O_IP), .MASK_OFS(O_MASK), .GW_OFS(O_GW)
  ) u_netid_bringup (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mac_addr(mac_addr), .ip_addr(ip_addr), .net_mask(net_mask), .gw_addr(gw_addr),
    .nic_rst_n(nic_rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .error(error), .err_field(err_field)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // responder model state
  logic [47:0] mem [4];
  logic [15:0] log_addr [16];
  logic        log_wr   [16];
  logic [2:0]  log_len  [16];
  logic [47:0] log_data [16];
  int          log_n = 0;
  int          bad_fld = 4;
  logic [47:0] bad_xor = 48'h0;

  function automatic int fld_of(input logic [15:0] a);
    if (a == O_MAC)  return 0;
    if (a == O_IP)   return 1;
    if (a == O_MASK) return 2;
    if (a == O_GW)   return 3;
    return -1;
  endfunction

  function automatic logic [47:0] fval(input int i);
    case (i)
      0:       return mac_addr;
      1:       return {16'h0, ip_addr};
      2:       return {16'h0, net_mask};
      default: return {16'h0, gw_addr};
    endcase
  endfunction

  function automatic logic [15:0] fofs(input int i);
    case (i)
      0:       return O_MAC;
      1:       return O_IP;
      2:       return O_MASK;
      default: return O_GW;
    endcase
  endfunction

  // SPI master / controller model, driven at the falling edge
  initial begin
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [15:0] a;
        logic        w;
        logic [47:0] d;
        int          f;
        a = req_addr; w = req_write; d = req_wdata;
        if (log_n < 16) begin
          log_addr[log_n] = a; log_wr[log_n] = w;
          log_len[log_n] = req_len; log_data[log_n] = d;
        end
        // R6: delay acceptance and require the request to stay put
        for (int k = 0; k < 1 + (log_n % 3); k++) begin
          @(negedge clk);
          chk(req_valid && req_addr == a && req_write == w && req_wdata == d,
              "R6 request held until ready", {15'h0, req_valid, req_addr, 32'h0},
              {15'h0, 1'b1, a, 32'h0});
        end
        log_n++;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        f = fld_of(a);
        for (int k = 0; k < 1 + (log_n % 2); k++) begin
          chk(!req_valid, "R6 no request while outstanding", {63'h0, req_valid}, 64'h0);
          @(negedge clk);
        end
        if (f >= 0) begin
          if (w) mem[f] = d;
          rsp_rdata = w ? 48'h0 : (mem[f] ^ ((f == bad_fld) ? bad_xor : 48'h0));
        end else begin
          rsp_rdata = 48'hDEAD_BEEF_0000;
        end
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input logic [47:0] m, input logic [31:0] ip,
                          input logic [31:0] mk, input logic [31:0] gw,
                          input int bf, input logic [47:0] bx, input bit mid_start);
    int lo, hi, n_exp, wait_c;
    bit re_reset;
    mac_addr = m; ip_addr = ip; net_mask = mk; gw_addr = gw;
    bad_fld = bf; bad_xor = bx;
    log_n = 0;
    pulse_start();
    lo = 0;
    while (!nic_rst_n && lo < 1000) begin
      chk(!req_valid, "R3 no request during reset", {63'h0, req_valid}, 64'h0);
      lo++;
      @(negedge clk);
    end
    chk(lo == HOLD, "R2 reset hold length", 64'(lo), 64'(HOLD));
    hi = 0;
    while (!req_valid && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == SETTLE, "R3 settle length before first request", 64'(hi), 64'(SETTLE));
    chk(busy, "R9 busy during sequence", {63'h0, busy}, 64'h1);
    re_reset = 0;
    if (mid_start) begin
      while (log_n < 3) @(negedge clk);
      pulse_start();
    end
    wait_c = 0;
    while (!done && !error && wait_c < 2000) begin
      if (!nic_rst_n) re_reset = 1;
      wait_c++;
      @(negedge clk);
    end
    if (mid_start)
      chk(!re_reset, "R9 start while busy ignored", {63'h0, re_reset}, 64'h0);
    n_exp = (bf < 4) ? 5 + bf : 8;
    repeat (5) @(negedge clk);
    chk(log_n == n_exp, "R7 request count", 64'(log_n), 64'(n_exp));
    for (int j = 0; j < n_exp && j < log_n; j++) begin
      int i;
      i = j % 4;
      chk(log_addr[j] == fofs(i), (j < 4) ? "R4 write offset order" : "R5 read offset order",
          64'(log_addr[j]), 64'(fofs(i)));
      chk(log_wr[j] == (j < 4), (j < 4) ? "R4 write direction" : "R5 read direction",
          64'(log_wr[j]), 64'(j < 4));
      chk(log_len[j] == ((i == 0) ? 3'd6 : 3'd4), (j < 4) ? "R4 length" : "R5 length",
          64'(log_len[j]), 64'((i == 0) ? 6 : 4));
      if (j < 4)
        chk(log_data[j] == fval(i), "R4 write data alignment", 64'(log_data[j]), 64'(fval(i)));
    end
    if (bf < 4) begin
      chk(error && !done, "R7 error raised", {62'h0, error, done}, 64'h2);
      chk(err_field == bf[1:0], "R7 failing field code", 64'(err_field), 64'(bf));
    end else begin
      chk(done && !error && !busy, "R8 done reported", {61'h0, done, error, busy}, 64'h4);
    end
    chk(!(done && error), "R10 done and error exclusive", {62'h0, done, error}, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    mac_addr = '0; ip_addr = '0; net_mask = '0; gw_addr = '0;
    repeat (3) @(negedge clk);
    chk(nic_rst_n && !req_valid && !busy && !done && !error, "R1 state in reset",
        {59'h0, nic_rst_n, req_valid, busy, done, error}, 64'h10);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(nic_rst_n && !req_valid && !busy && !done && !error, "R1 idle after reset",
        {59'h0, nic_rst_n, req_valid, busy, done, error}, 64'h10);

    run_case(48'h0102_0304_0506, 32'hC0A8_0164, 32'hFFFF_FF00, 32'hC0A8_0101, 4, 48'h0, 0);
    run_case(48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4, 48'h0, 0);
    for (int f = 0; f < 4; f++)
      run_case(48'h00AA_BBCC_DDEE + 48'(f), 32'h0A00_0002 + 32'(f), 32'hFFFF_0000,
               32'h0A00_0001, f, 48'h0000_0000_0100, 0);
    // R7: corruption only in the padding bytes of a 4-byte field
    run_case(48'h0200_0000_0001, 32'hAC10_0005, 32'hFFF0_0000, 32'hAC10_0001,
             3, 48'h0100_0000_0000, 0);
    // R9: retry from the failed state, then a start pulse mid-sequence
    run_case(48'h1234_5678_9ABC, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 4, 48'h0, 1);
    // R10: done holds with no start
    repeat (20) @(negedge clk);
    chk(done && !error, "R10 done held", {62'h0, done, error}, 64'h2);
    run_case(48'h0000_0000_0000, 32'h8000_0001, 32'hFFFF_FFFC, 32'h8000_0002,
             1, 48'h0000_8000_0000, 0);
    repeat (20) @(negedge clk);
    chk(error && err_field == 2'd1, "R10 error and field held",
        {61'h0, error, err_field}, 64'h5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule